// File: doc/BRIEF.md
# Multi-Slot Serial Byte DMA Channel

This block is one DMA channel that moves bytes between a simple memory port and a serial device's byte FIFOs. In transmit mode it reads memory and streams the bytes into the device transmit FIFO. In receive mode it drains the device receive FIFO into memory. Software sets up a small register file before starting the channel. It loads a start address and a byte count into any of four descriptor slots and arms the slots it wants. It then sets the beat width and burst length that bound each memory request, and finally sets the channel's run bit.

The channel visits the armed slots in ascending order and skips the unarmed ones. Each slot's address register advances and its size register counts down as the transfer proceeds, so software can read the residue at any time. Completion, receive-idle timeout and memory error are recorded in a status word that clears itself when read. A single interrupt line is raised while any recorded event has its enable set. Clearing the run bit in the middle of a transfer freezes the channel, and setting it again resumes from the same point.

Top module: `serdma_chan`

## Requirements
- R1: After reset, every register reads zero, the interrupt is low and no memory request is raised.
- R2: With control bit 1 clear (transmit), each byte accepted from the memory read stream is presented unchanged to the device transmit FIFO, and a request's byte count is delivered before the next request is raised.
- R3: With control bit 1 set (receive), bytes from the device receive FIFO go unchanged to the memory write stream, requests are flagged as writes, and the transmit side stays idle.
- R4: Each memory request carries the slot's current address and a byte count equal to the smaller of the bytes left in the slot and burst×beat (word 2 holds the burst length, word 3 the beat width in bytes, and a zero product is treated as 1). The request holds steady until it is accepted.
- R5: The slots whose arm bits (descriptor-control bits 3:0) are set are processed in ascending index order, and unarmed slots are left untouched. When a slot finishes, its completion flag (status bits 3:0) is set and its arm bit is cleared.
- R6: When a slot whose stop bit (descriptor-control bits 11:8) is set finishes, the channel halts and its run bit (control bit 0) reads 0.
- R7: A slot's size register (word 9+2·slot) counts down by one per byte moved. Its address register (word 8+2·slot) advances by each request's byte count when that request is accepted.
- R8: Writing 0 to control bit 0 during a transfer stops all memory and device handshakes and leaves the residue unchanged. Writing it back to 1 completes the remaining bytes without reprogramming.
- R9: Reading status (word 4) returns the recorded flags and clears them, so a second read returns 0.
- R10: In receive mode, if the active slot's timeout enable (descriptor-control bits 7:4) is set and no receive byte is offered for the number of cycles in word 5 (0 disables), that slot's timeout flag (status bits 7:4) is set and the transfer goes on.
- R11: A memory error pulse during a transfer sets status bit 8. If stop-on-error (descriptor-control bit 16) is set, the channel also halts and clears its run bit.
- R12: The interrupt is high while a completion flag with its done enable (descriptor-control bits 15:12), a timeout flag with its timeout enable, or the error flag with its enable (descriptor-control bit 17) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears status on word 4) |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write (receive mode) |
| mem_req_addr | output | 32 | Request start address |
| mem_req_len | output | 16 | Request byte count |
| mem_rd_valid | input | 1 | Memory read byte valid |
| mem_rd_data | input | 8 | Memory read byte |
| mem_rd_ready | output | 1 | Memory read byte taken |
| mem_wr_valid | output | 1 | Memory write byte valid |
| mem_wr_data | output | 8 | Memory write byte |
| mem_wr_ready | input | 1 | Memory write byte taken |
| mem_err | input | 1 | Memory error pulse |
| dev_tx_valid | output | 1 | Byte offered to device transmit FIFO |
| dev_tx_data | output | 8 | Transmit byte |
| dev_tx_ready | input | 1 | Device transmit FIFO has room |
| dev_rx_valid | input | 1 | Device receive FIFO has a byte |
| dev_rx_data | input | 8 | Receive byte |
| dev_rx_ready | output | 1 | Receive byte taken |
| irq | output | 1 | Interrupt |

## Verification
A wrong slot index or a wrong remaining count shows up at the memory port on the very next request. That request carries a wrong address or length, or it goes to a slot that was never armed. A corrupted phase or a lost run bit shows up as valid strobes that keep toggling while the channel should be paused or halted, or that stay silent while it should be running; this is visible within one or two cycles. An error in the status bookkeeping cannot be seen on the data ports. It appears only at the interrupt line and at the next status read, which is why every scenario ends by reading status twice and sampling the interrupt around those reads.

// File: rtl/serdma_chan.sv
module serdma_chan #(
  parameter int AW    = 32,
  parameter int SLOTS = 4,
  parameter int SW    = 16,
  parameter int TW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [SW-1:0] mem_req_len,
  input  logic          mem_rd_valid,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_rd_ready,
  output logic          mem_wr_valid,
  output logic [7:0]    mem_wr_data,
  input  logic          mem_wr_ready,
  input  logic          mem_err,
  output logic          dev_tx_valid,
  output logic [7:0]    dev_tx_data,
  input  logic          dev_tx_ready,
  input  logic          dev_rx_valid,
  input  logic [7:0]    dev_rx_data,
  output logic          dev_rx_ready,
  output logic          irq
);
  localparam int CW        = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SLOT_BASE = 8;
  localparam int DCW       = 4 * SLOTS + 2;

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_DATA} phase_t;

  phase_t            ph;
  logic              run, dir, soe, eie;
  logic [SLOTS-1:0]  arm, tmo_en, stop_en, done_en;
  logic [SLOTS-1:0]  st_done, st_tmo;
  logic              st_err;
  logic [7:0]        burst, beat;
  logic [TW-1:0]     tmo_lim, idle_cnt;
  logic [AW-1:0]     saddr [SLOTS];
  logic [SW-1:0]     ssize [SLOTS];
  logic [CW-1:0]     cur, first, nxt;
  logic [SW-1:0]     chunk, cur_size, req_len;
  logic [31:0]       bb, bbx;
  logic              any_arm, nxt_ok, act, byte_fire, slot_end, chunk_end;
  logic              err_hit, rd_stat, tmo_hit;

  always_comb begin
    any_arm = 1'b0;
    nxt_ok  = 1'b0;
    first   = '0;
    nxt     = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (arm[i]) begin
        any_arm = 1'b1;
        first   = CW'(i);
      end
      if (arm[i] && i > int'(cur)) begin
        nxt_ok = 1'b1;
        nxt    = CW'(i);
      end
    end
  end

  assign cur_size = ssize[cur];
  assign bb       = 32'(burst) * 32'(beat);
  assign bbx      = (bb == 0) ? 32'd1 : bb;
  assign req_len  = (32'(cur_size) < bbx) ? cur_size : SW'(bbx);

  assign act          = (ph == PH_DATA) && run;
  assign mem_req_valid = (ph == PH_REQ) && run && (cur_size != 0);
  assign mem_req_write = dir;
  assign mem_req_addr  = saddr[cur];
  assign mem_req_len   = req_len;
  assign dev_tx_valid  = act && !dir && mem_rd_valid;
  assign dev_tx_data   = mem_rd_data;
  assign mem_rd_ready  = act && !dir && dev_tx_ready;
  assign mem_wr_valid  = act && dir && dev_rx_valid;
  assign mem_wr_data   = dev_rx_data;
  assign dev_rx_ready  = act && dir && mem_wr_ready;

  assign byte_fire = act && (dir ? (dev_rx_valid && mem_wr_ready) : (mem_rd_valid && dev_tx_ready));
  assign slot_end  = run && (((ph == PH_REQ) && (cur_size == 0)) || (byte_fire && (cur_size == 1)));
  assign chunk_end = byte_fire && (chunk == 1) && (cur_size != 1);
  assign err_hit   = mem_err && (ph != PH_IDLE);
  assign rd_stat   = reg_re && (reg_addr == 5'd4);
  assign tmo_hit   = run && dir && (ph != PH_IDLE) && !dev_rx_valid && (tmo_lim != 0)
                     && tmo_en[cur] && (idle_cnt == tmo_lim - 1'b1);

  assign irq = |(st_done & done_en) | |(st_tmo & tmo_en) | (st_err & eie);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      5'd0: reg_rdata = 32'({dir, run});
      5'd1: reg_rdata = 32'({eie, soe, done_en, stop_en, tmo_en, arm});
      5'd2: reg_rdata = 32'(burst);
      5'd3: reg_rdata = 32'(beat);
      5'd4: reg_rdata = 32'({st_err, st_tmo, st_done});
      5'd5: reg_rdata = 32'(tmo_lim);
      default: ;
    endcase
    for (int i = 0; i < SLOTS; i++) begin
      if (reg_addr == 5'(SLOT_BASE + 2 * i))     reg_rdata = 32'(saddr[i]);
      if (reg_addr == 5'(SLOT_BASE + 2 * i + 1)) reg_rdata = 32'(ssize[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
      {run, dir, soe, eie} <= '0;
      {arm, tmo_en, stop_en, done_en, st_done, st_tmo} <= '0;
      st_err   <= 1'b0;
      burst    <= '0;
      beat     <= '0;
      tmo_lim  <= '0;
      idle_cnt <= '0;
      cur      <= '0;
      chunk    <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        saddr[i] <= '0;
        ssize[i] <= '0;
      end
    end else begin
      if (reg_we) begin
        case (reg_addr)
          5'd0: {dir, run} <= reg_wdata[1:0];
          5'd1: {eie, soe, done_en, stop_en, tmo_en, arm} <= reg_wdata[DCW-1:0];
          5'd2: burst   <= reg_wdata[7:0];
          5'd3: beat    <= reg_wdata[7:0];
          5'd5: tmo_lim <= reg_wdata[TW-1:0];
          default: ;
        endcase
        for (int i = 0; i < SLOTS; i++) begin
          if (reg_addr == 5'(SLOT_BASE + 2 * i))     saddr[i] <= reg_wdata[AW-1:0];
          if (reg_addr == 5'(SLOT_BASE + 2 * i + 1)) ssize[i] <= reg_wdata[SW-1:0];
        end
      end

      if (rd_stat) begin
        st_done <= '0;
        st_tmo  <= '0;
        st_err  <= 1'b0;
      end

      if (byte_fire || ph == PH_IDLE || !run || dev_rx_valid || tmo_hit) idle_cnt <= '0;
      else if (dir) idle_cnt <= idle_cnt + 1'b1;
      if (tmo_hit) st_tmo[cur] <= 1'b1;

      case (ph)
        PH_IDLE: if (run && any_arm) begin
          cur <= first;
          ph  <= PH_REQ;
        end
        PH_REQ: if (mem_req_valid && mem_req_ready) begin
          chunk      <= req_len;
          saddr[cur] <= saddr[cur] + AW'(req_len);
          ph         <= PH_DATA;
        end
        PH_DATA: if (byte_fire) begin
          ssize[cur] <= cur_size - 1'b1;
          chunk      <= chunk - 1'b1;
          if (chunk_end) ph <= PH_REQ;
        end
        default: ph <= PH_IDLE;
      endcase

      if (slot_end) begin
        st_done[cur] <= 1'b1;
        arm[cur]     <= 1'b0;
        if (stop_en[cur]) begin
          run <= 1'b0;
          ph  <= PH_IDLE;
        end else if (nxt_ok) begin
          cur <= nxt;
          ph  <= PH_REQ;
        end else begin
          ph <= PH_IDLE;
        end
      end

      if (err_hit) begin
        st_err <= 1'b1;
        if (soe) begin
          run <= 1'b0;
          ph  <= PH_IDLE;
        end
      end
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (!run || (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len))));

  p_req_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len != 0) && (32'(mem_req_len) <= bbx));

  p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid || dev_rx_ready) |-> !(dev_tx_valid || mem_rd_ready));

  p_paused_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(mem_req_valid || dev_tx_valid || mem_wr_valid || mem_rd_ready || dev_rx_ready));

  p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && stop_en[cur] && !reg_we) |=> (!run && ph == PH_IDLE));
endmodule

// File: tb/serdma_chan_tb.sv
module serdma_chan_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_re = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [15:0] mem_req_len;
  logic mem_rd_valid = 1'b1, mem_rd_ready;
  logic [7:0] mem_rd_data;
  logic mem_wr_valid, mem_wr_ready = 1'b1;
  logic [7:0] mem_wr_data;
  logic mem_err = 1'b0;
  logic dev_tx_valid, dev_tx_ready = 1'b1;
  logic [7:0] dev_tx_data;
  logic dev_rx_valid = 1'b0, dev_rx_ready;
  logic [7:0] dev_rx_data = '0;
  logic irq;

  int checks = 0, errors = 0;
  int n_req, first_len, last_len, n_tx, n_wr, req_wr, tx_bad;
  int addr_log [8];
  int wr_log [8];
  logic [7:0] src_byte = '0;
  logic tx_fire_prev = 1'b0;
  logic [31:0] rv;

  assign mem_rd_data = src_byte;

  always #2 clk = ~clk;

  serdma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_rd_ready(mem_rd_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready), .mem_err(mem_err), .dev_tx_valid(dev_tx_valid),
    .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready), .dev_rx_valid(dev_rx_valid),
    .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready), .irq(irq)
  );

  always @(negedge clk) begin
    if (tx_fire_prev) src_byte <= src_byte + 8'd1;
    #1;
    tx_fire_prev = 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (n_req == 0) first_len = int'(mem_req_len);
      last_len = int'(mem_req_len);
      if (n_req < 8) addr_log[n_req] = int'(mem_req_addr);
      if (mem_req_write) req_wr++;
      n_req++;
    end
    if (dev_tx_valid && dev_tx_ready) begin
      if (dev_tx_data != src_byte) tx_bad++;
      n_tx++;
      tx_fire_prev = 1'b1;
    end
    if (mem_wr_valid && mem_wr_ready) begin
      if (n_wr < 8) wr_log[n_wr] = int'(mem_wr_data);
      n_wr++;
    end
  end

  task automatic clr_mon();
    n_req = 0; first_len = -1; last_len = -1; n_tx = 0; n_wr = 0; req_wr = 0; tx_bad = 0;
    for (int i = 0; i < 8; i++) begin
      addr_log[i] = -1;
      wr_log[i] = -1;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = 5'(a);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    dev_rx_valid = 1'b1; dev_rx_data = b;
    forever begin
      #1;
      if (dev_rx_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    dev_rx_valid = 1'b0;
  endtask

  localparam int VB [4] = '{4, 2, 1, 3};
  localparam int VW [4] = '{1, 4, 16, 2};
  localparam int VS [4] = '{10, 8, 40, 5};
  localparam int VN [4] = '{3, 1, 3, 1};
  localparam int VF [4] = '{4, 8, 16, 5};
  localparam int VL [4] = '{2, 8, 8, 5};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b0;
    clr_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(irq == 0 && mem_req_valid == 0, "R1", "irq/req after reset", int'(irq), 0);
    rd(0, rv); check(rv == 0, "R1", "control reset", int'(rv), 0);
    rd(1, rv); check(rv == 0, "R1", "descriptor control reset", int'(rv), 0);
    rd(4, rv); check(rv == 0, "R1", "status reset", int'(rv), 0);
    rd(9, rv); check(rv == 0, "R1", "slot0 size reset", int'(rv), 0);

    for (int v = 0; v < 4; v++) begin
      clr_mon();
      wr(1, 32'h0000_0101);
      wr(2, VB[v]); wr(3, VW[v]);
      wr(8, 32'h100); wr(9, VS[v]);
      wr(0, 1);
      repeat (3 * VS[v] + 40) @(negedge clk);
      check(n_req == VN[v], "R4", "request count", n_req, VN[v]);
      check(first_len == VF[v], "R4", "first request length", first_len, VF[v]);
      check(last_len == VL[v], "R4", "last request length", last_len, VL[v]);
      check(n_tx == VS[v] && tx_bad == 0, "R2", "bytes to device", n_tx, VS[v]);
      rd(9, rv); check(rv == 0, "R7", "residue at end", int'(rv), 0);
      rd(8, rv); check(rv == 32'h100 + VS[v], "R7", "address advanced", int'(rv), 32'h100 + VS[v]);
      rd(0, rv); check(rv == 0, "R6", "run cleared by stop slot", int'(rv), 0);
      rd(4, rv); check(rv == 1, "R5", "slot0 completion flag", int'(rv), 1);
    end

    clr_mon();
    wr(2, 16); wr(3, 1);
    wr(8, 32'h200); wr(9, 3);
    wr(10, 32'h300); wr(11, 7);
    wr(12, 32'h400); wr(13, 2);
    wr(1, 32'h0000_4405);
    wr(0, 1);
    repeat (60) @(negedge clk);
    check(n_req == 2, "R5", "armed slots requested", n_req, 2);
    check(addr_log[0] == 32'h200, "R5", "slot0 first", addr_log[0], 32'h200);
    check(addr_log[1] == 32'h400, "R5", "slot2 second, slot1 skipped", addr_log[1], 32'h400);
    check(n_tx == 5, "R2", "bytes across two slots", n_tx, 5);
    rd(11, rv); check(rv == 7, "R5", "unarmed slot1 size untouched", int'(rv), 7);
    #1 check(irq == 1, "R12", "irq from enabled completion", int'(irq), 1);
    rd(4, rv); check(rv == 5, "R9", "status completion flags", int'(rv), 5);
    #1 check(irq == 0, "R12", "irq after status read", int'(irq), 0);
    rd(4, rv); check(rv == 0, "R9", "status cleared by read", int'(rv), 0);
    rd(1, rv); check(rv == 32'h4400, "R5", "arm bits cleared", int'(rv), 32'h4400);

    clr_mon();
    wr(2, 1); wr(3, 1);
    wr(8, 0); wr(9, 20);
    wr(1, 32'h0000_0101);
    wr(0, 1);
    repeat (12) @(negedge clk);
    wr(0, 0);
    repeat (2) @(negedge clk);
    b0 = n_tx;
    check(b0 > 0 && b0 < 20, "R8", "bytes before pause", b0, 10);
    rd(9, rv); check(int'(rv) == 20 - b0, "R7", "residue at pause", int'(rv), 20 - b0);
    repeat (10) @(negedge clk);
    check(n_tx == b0, "R8", "no bytes while paused", n_tx, b0);
    wr(0, 1);
    repeat (80) @(negedge clk);
    check(n_tx == 20 && tx_bad == 0, "R8", "resume completes", n_tx, 20);
    rd(9, rv); check(rv == 0, "R8", "residue after resume", int'(rv), 0);
    rd(4, rv);

    clr_mon();
    wr(5, 5); wr(2, 4); wr(3, 1);
    wr(10, 32'h300); wr(11, 4);
    wr(1, 32'h0000_0222);
    wr(0, 3);
    send_rx(8'hA1);
    send_rx(8'hA2);
    repeat (20) @(negedge clk);
    rd(11, rv); check(rv == 2, "R7", "receive residue mid-slot", int'(rv), 2);
    send_rx(8'hA3);
    send_rx(8'hA4);
    repeat (10) @(negedge clk);
    check(n_wr == 4, "R3", "bytes written to memory", n_wr, 4);
    check(wr_log[0] == 32'hA1 && wr_log[3] == 32'hA4, "R3", "receive data order", wr_log[3], 32'hA4);
    check(req_wr == 1 && n_tx == 0, "R3", "write request, transmit idle", req_wr, 1);
    #1 check(irq == 1, "R12", "irq from timeout", int'(irq), 1);
    rd(4, rv); check(rv == 32'h22, "R10", "timeout and completion flags slot1", int'(rv), 32'h22);

    clr_mon();
    dev_tx_ready = 1'b0;
    wr(8, 0); wr(9, 50);
    wr(1, 32'h0003_0001);
    wr(0, 1);
    repeat (5) @(negedge clk);
    mem_err = 1'b1;
    @(negedge clk);
    mem_err = 1'b0;
    repeat (2) @(negedge clk);
    check(n_tx == 0, "R11", "no bytes with device full", n_tx, 0);
    rd(0, rv); check(rv == 0, "R11", "run cleared on error", int'(rv), 0);
    #1 check(irq == 1, "R12", "irq from error", int'(irq), 1);
    rd(4, rv); check(rv == 32'h100, "R11", "error flag", int'(rv), 32'h100);
    dev_tx_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(n_tx == 0, "R11", "halted channel stays idle", n_tx, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule